// File: doc/BRIEF.md
# Bootstrap Program Download Sequencer

The block loads a short program into a target microcontroller that waits in serial bootstrap mode. A host controller issues one command carrying a program length, a length mode and the address values the program needs at run time. The block then drives the target's reset output for a fixed number of cycles and streams the program bytes, which it fetches from a local buffer through a byte-read port, out of a slow TTL-level UART transmitter. After the program it sends an 8-byte parameter trailer. The loaded code finds its own working addresses in this trailer, so one program image runs on every target variant.

Targets come in two kinds. A variable-length target receives only the program and the trailer, and starts running once the line has been quiet for more than five byte times. The block holds the line idle for that gap before it reports completion. A fixed-length target needs an image of exactly `FIXED_LEN` bytes, so the block fills the space between the program and the trailer with zero bytes. A device-query command always uses the fixed length. Any byte the target sends back while a sequence is running is passed to the host unchanged.

Top module: `boot_dl_seq`

## Requirements
- R1: An accepted command drives `tgt_reset` high for exactly `RESET_CYCLES` clock cycles. `tx` stays high throughout, and serial output starts only after `tgt_reset` falls.
- R2: Each byte goes out as one 8N1 frame, least significant bit first: a low start bit, 8 data bits and a high stop bit, each lasting `CLK_PER_BIT` clocks. The line idles high.
- R3: In variable mode (`cmd_fixed`=0, `cmd_query`=0) the block sends buffer bytes 0 to `cmd_len`-1, followed at once by the 8-byte trailer, for `cmd_len`+8 frames in total.
- R4: The trailer holds four 16-bit values, each sent high byte first, in this order: `cmd_start_addr`, `cmd_end_addr`, the register base, and the RAM origin. The register base is 0x1000 and the RAM origin is 0x0000 when `cmd_alt_map`=0. They are 0x0000 and 0x0040 when `cmd_alt_map`=1.
- R5: In fixed mode the block sends exactly `FIXED_LEN` frames: the `cmd_len` program bytes, then 0x00 pad bytes, then the trailer in the last 8 frames.
- R6: `cmd_query`=1 selects fixed mode whatever the value of `cmd_fixed`.
- R7: In variable mode `done` rises no sooner than `IDLE_BYTES`*10 bit times after the end of the last stop bit. In fixed mode it rises within one bit time of that point.
- R8: The command is rejected with `err`=1 when the variable-mode length is 0 or greater than 2^`AW`, or when the fixed-mode length is greater than `FIXED_LEN`-8. A rejected command produces no reset pulse, no frames and no `busy`.
- R9: `busy` is high from acceptance to completion and the line is high whenever `busy` is low. `done` and `err` hold their value until the next accepted command and are never high together. A command that arrives while `busy` is high is ignored.
- R10: A frame received on `rx` while `busy` is high produces a one-cycle `rx_valid` pulse with the byte on `rx_byte`. No pulse is produced while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_len | input | AW+2 | Program length in bytes |
| cmd_fixed | input | 1 | Select fixed-length padded image |
| cmd_query | input | 1 | Device-query transfer, forces fixed length |
| cmd_alt_map | input | 1 | Target uses the alternate memory map |
| cmd_start_addr | input | 16 | Start address placed in the trailer |
| cmd_end_addr | input | 16 | End address placed in the trailer |
| buf_addr | output | AW | Program buffer read address |
| buf_data | input | 8 | Buffer byte, valid one cycle after buf_addr |
| tx | output | 1 | Serial line to the target |
| rx | input | 1 | Serial line from the target |
| tgt_reset | output | 1 | Target reset drive, high asserts reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| err | output | 1 | Last command rejected |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |

## Verification
The reset pulse is counted cycle by cycle on falling clock edges and must equal `RESET_CYCLES` exactly. Serial bytes are recovered by a bench decoder that samples the middle of each bit, one and a half bit times after the falling edge of the start bit and every bit time after that. `done` is timed from the start of the last frame. It is due 10 bit times later in fixed mode and a further `IDLE_BYTES`*10 bit times later in variable mode, and each check allows one bit time of slack for the start-bit detection and the sequencer hand-off. Rejection checks sample `err`, `busy` and the line a few cycles after the strobe, once the one registered decision has settled.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;

    localparam int TRAILER_BYTES = 8;
    localparam logic [15:0] REG_BASE_STD = 16'h1000;
    localparam logic [15:0] REG_BASE_ALT = 16'h0000;
    localparam logic [15:0] RAM_ORG_STD  = 16'h0000;
    localparam logic [15:0] RAM_ORG_ALT  = 16'h0040;
    localparam logic [7:0]  PAD_BYTE     = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_SEND,
        ST_DRAIN,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic [15:0] start_addr;
        logic [15:0] end_addr;
        logic [15:0] reg_base;
        logic [15:0] ram_org;
    } trailer_t;

    function automatic trailer_t make_trailer(logic [15:0] s, logic [15:0] e, logic alt);
        trailer_t t;
        t.start_addr = s;
        t.end_addr   = e;
        t.reg_base   = alt ? REG_BASE_ALT : REG_BASE_STD;
        t.ram_org    = alt ? RAM_ORG_ALT  : RAM_ORG_STD;
        return t;
    endfunction

    // byte 0 is the most significant byte of the packed trailer
    function automatic logic [7:0] trailer_byte(trailer_t t, logic [2:0] idx);
        logic [63:0] flat;
        flat = t;
        return flat[63 - 8*idx -: 8];
    endfunction

endpackage

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
    parameter int CLK_PER_BIT = 6144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output logic       tx,
    output logic       ready
);
    localparam int CW = $clog2(CLK_PER_BIT);

    logic [9:0]    frame;
    logic [3:0]    bits_left;
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame     <= '1;
            bits_left <= '0;
            cnt       <= '0;
            active    <= 1'b0;
        end else if (load && !active) begin
            frame     <= {1'b1, data, 1'b0};
            bits_left <= 4'd10;
            cnt       <= '0;
            active    <= 1'b1;
        end else if (active) begin
            if (cnt == CW'(CLK_PER_BIT - 1)) begin
                cnt       <= '0;
                frame     <= {1'b1, frame[9:1]};
                bits_left <= bits_left - 4'd1;
                if (bits_left == 4'd1)
                    active <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign tx    = frame[0];
    assign ready = !active;

endmodule

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
    parameter int CLK_PER_BIT = 6144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx,
    output logic       valid,
    output logic [7:0] data
);
    localparam int CW   = $clog2(CLK_PER_BIT);
    localparam int HALF = CLK_PER_BIT / 2;

    logic [1:0]    sync;
    logic          line;
    logic          active;
    logic [3:0]    idx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign line = sync[1];
    assign lim  = (idx == 4'd0) ? CW'(HALF - 1) : CW'(CLK_PER_BIT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= 2'b11;
            active <= 1'b0;
            idx    <= '0;
            cnt    <= '0;
            data   <= '0;
            valid  <= 1'b0;
        end else begin
            sync  <= {sync[0], rx};
            valid <= 1'b0;
            if (!active) begin
                if (!line) begin
                    active <= 1'b1;
                    idx    <= '0;
                    cnt    <= '0;
                end
            end else if (cnt == lim) begin
                cnt <= '0;
                idx <= idx + 4'd1;
                if (idx == 4'd0) begin
                    if (line)
                        active <= 1'b0;
                end else if (idx == 4'd9) begin
                    active <= 1'b0;
                    valid  <= line;
                end else begin
                    data <= {line, data[7:1]};
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/boot_byte_src.sv
module boot_byte_src
    import boot_dl_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic [LEN_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] total,
    input  logic [7:0]       buf_data,
    input  trailer_t         trailer,
    output logic [7:0]       byte_out
);
    logic [LEN_W-1:0] trail_start;
    logic [2:0]       tidx;

    assign trail_start = total - LEN_W'(TRAILER_BYTES);
    assign tidx        = pos[2:0] - trail_start[2:0];

    always_comb begin
        if (pos < len)
            byte_out = buf_data;
        else if (pos < trail_start)
            byte_out = PAD_BYTE;
        else
            byte_out = trailer_byte(trailer, tidx);
    end

endmodule

// File: rtl/boot_dl_seq.sv
module boot_dl_seq
    import boot_dl_pkg::*;
#(
    parameter int CLK_PER_BIT  = 6144,
    parameter int RESET_CYCLES = 4800000,
    parameter int IDLE_BYTES   = 6,
    parameter int FIXED_LEN    = 256,
    parameter int AW           = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [AW+1:0]   cmd_len,
    input  logic            cmd_fixed,
    input  logic            cmd_query,
    input  logic            cmd_alt_map,
    input  logic [15:0]     cmd_start_addr,
    input  logic [15:0]     cmd_end_addr,
    output logic [AW-1:0]   buf_addr,
    input  logic [7:0]      buf_data,
    output logic            tx,
    input  logic            rx,
    output logic            tgt_reset,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            rx_valid,
    output logic [7:0]      rx_byte
);
    localparam int LEN_W      = AW + 2;
    localparam int GAP_CYCLES = IDLE_BYTES * 10 * CLK_PER_BIT;
    localparam int RW         = $clog2(RESET_CYCLES + 1);
    localparam int GW         = $clog2(GAP_CYCLES + 1);
    localparam int WW         = (RW > GW) ? RW : GW;

    seq_state_t       state;
    logic [LEN_W-1:0] pos, len_q, total_q;
    logic             fixed_q;
    trailer_t         trailer_q;
    logic [WW-1:0]    wait_cnt;
    logic             eff_fixed, bad_cmd;
    logic             tx_ready, tx_load;
    logic [7:0]       next_byte;
    logic             rx_strobe;

    assign eff_fixed = cmd_fixed | cmd_query;
    assign bad_cmd   = eff_fixed
                     ? (cmd_len > LEN_W'(FIXED_LEN - TRAILER_BYTES))
                     : ((cmd_len == '0) || (cmd_len > LEN_W'(2**AW)));

    assign busy      = (state != ST_IDLE);
    assign tgt_reset = (state == ST_RESET);
    assign tx_load   = (state == ST_SEND) && (pos < total_q) && tx_ready;
    assign buf_addr  = pos[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pos       <= '0;
            len_q     <= '0;
            total_q   <= '0;
            fixed_q   <= 1'b0;
            trailer_q <= '0;
            wait_cnt  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        done <= 1'b0;
                        err  <= bad_cmd;
                        if (!bad_cmd) begin
                            state     <= ST_RESET;
                            wait_cnt  <= '0;
                            pos       <= '0;
                            len_q     <= cmd_len;
                            fixed_q   <= eff_fixed;
                            total_q   <= eff_fixed ? LEN_W'(FIXED_LEN)
                                                   : cmd_len + LEN_W'(TRAILER_BYTES);
                            trailer_q <= make_trailer(cmd_start_addr, cmd_end_addr, cmd_alt_map);
                        end
                    end
                end
                ST_RESET: begin
                    if (wait_cnt == WW'(RESET_CYCLES - 1))
                        state <= ST_SEND;
                    else
                        wait_cnt <= wait_cnt + WW'(1);
                end
                ST_SEND: begin
                    if (tx_load)
                        pos <= pos + LEN_W'(1);
                    else if (pos == total_q)
                        state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (tx_ready) begin
                        if (fixed_q) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            wait_cnt <= '0;
                            state    <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (wait_cnt == WW'(GAP_CYCLES - 1)) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + WW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    boot_byte_src #(.LEN_W(LEN_W)) u_src (
        .pos      (pos),
        .len      (len_q),
        .total    (total_q),
        .buf_data (buf_data),
        .trailer  (trailer_q),
        .byte_out (next_byte)
    );

    boot_uart_tx #(.CLK_PER_BIT(CLK_PER_BIT)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_load),
        .data  (next_byte),
        .tx    (tx),
        .ready (tx_ready)
    );

    boot_uart_rx #(.CLK_PER_BIT(CLK_PER_BIT)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .rx    (rx),
        .valid (rx_strobe),
        .data  (rx_byte)
    );

    assign rx_valid = rx_strobe && busy;

endmodule

// File: rtl/boot_dl_seq_chk.sv
module boot_dl_seq_chk (
    input logic clk,
    input logic rst,
    input logic tx,
    input logic tgt_reset,
    input logic busy,
    input logic done,
    input logic err,
    input logic rx_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_reset |-> tx);

    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_reset) |-> !$past(busy));

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R9
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && !busy));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy);

    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> busy);

endmodule

bind boot_dl_seq boot_dl_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx        (tx),
    .tgt_reset (tgt_reset),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rx_valid  (rx_valid)
);

// File: tb/boot_dl_seq_test.sv
module boot_dl_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int RST_CYC    = 30;
    localparam int IDLE_B     = 6;
    localparam int FIX_LEN    = 32;
    localparam int AW         = 6;
    localparam int GAP        = IDLE_B * 10 * CPB;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_fixed = 0, cmd_query = 0, cmd_alt_map = 0;
    logic [AW+1:0] cmd_len = '0;
    logic [15:0] cmd_start_addr = '0, cmd_end_addr = '0;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_data;
    logic tx, rx = 1, tgt_reset, busy, done, err, rx_valid;
    logic [7:0] rx_byte;

    int total = 0, bad = 0, cyc = 0, rst_seen = 0, frame_bad = 0, last_start = 0;
    bit finished = 0;
    logic [7:0] mem [64];
    logic [7:0] cap[$];
    logic [7:0] rx_cap[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) buf_data <= mem[buf_addr];
    always @(negedge clk) if (tgt_reset) rst_seen++;
    always @(negedge clk) if (rx_valid) rx_cap.push_back(rx_byte);

    boot_dl_seq #(.CLK_PER_BIT(CPB), .RESET_CYCLES(RST_CYC), .IDLE_BYTES(IDLE_B),
                  .FIXED_LEN(FIX_LEN), .AW(AW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
        .cmd_fixed(cmd_fixed), .cmd_query(cmd_query), .cmd_alt_map(cmd_alt_map),
        .cmd_start_addr(cmd_start_addr), .cmd_end_addr(cmd_end_addr),
        .buf_addr(buf_addr), .buf_data(buf_data), .tx(tx), .rx(rx),
        .tgt_reset(tgt_reset), .busy(busy), .done(done), .err(err),
        .rx_valid(rx_valid), .rx_byte(rx_byte));

    // serial decoder: mid-bit sampling
    initial begin
        logic [7:0] v;
        int st;
        forever begin
            @(negedge clk);
            if (tx === 1'b0) begin
                st = cyc;
                repeat (CPB/2) @(negedge clk);
                for (int b = 0; b < 8; b++) begin
                    repeat (CPB) @(negedge clk);
                    v[b] = tx;
                end
                repeat (CPB) @(negedge clk);
                if (tx !== 1'b1) frame_bad++;
                cap.push_back(v);
                last_start = st;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int i, int len, int tot, logic [15:0] s,
                                            logic [15:0] e, logic alt);
        logic [63:0] t;
        t = {s, e, alt ? 16'h0000 : 16'h1000, alt ? 16'h0040 : 16'h0000};
        if (i < len) return mem[i % 64];
        if (i < tot - 8) return 8'h00;
        return t[63 - 8*(i - (tot - 8)) -: 8];
    endfunction

    task automatic send_rx(logic [7:0] b);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        for (int k = 0; k < 10; k++) begin
            rx = f[k];
            repeat (CPB) @(negedge clk);
        end
        rx = 1'b1;
    endtask

    task automatic pulse_cmd(int len, bit fx, bit q, bit alt, logic [15:0] s, logic [15:0] e);
        @(negedge clk);
        cmd_len = (AW+2)'(len); cmd_fixed = fx; cmd_query = q; cmd_alt_map = alt;
        cmd_start_addr = s; cmd_end_addr = e; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic run(int len, bit fx, bit q, bit alt, logic [15:0] s, logic [15:0] e,
                       bit poke, bit rx_inj);
        int base, rbase, rxbase, fbase, tot, n, d, mism, lo, hi;
        bit effx;
        effx = fx | q;
        tot = effx ? FIX_LEN : len + 8;
        base = cap.size(); rbase = rst_seen; rxbase = rx_cap.size(); fbase = frame_bad;
        pulse_cmd(len, fx, q, alt, s, e);
        check(busy === 1'b1 && done === 1'b0, "R9", "busy after accept", busy, 1);
        n = 0;
        fork
            begin
                while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
            end
            begin
                if (poke) begin
                    repeat (200) @(negedge clk);
                    cmd_len = 3; cmd_valid = 1;
                    @(negedge clk);
                    cmd_valid = 0;
                end
                if (rx_inj) begin
                    repeat (100) @(negedge clk);
                    send_rx(8'hA5);
                end
            end
        join
        d = cyc - last_start;
        check(done === 1'b1 && err === 1'b0 && busy === 1'b0, "R9", "done status", done, 1);
        check(rst_seen - rbase == RST_CYC, "R1", "reset pulse cycles", rst_seen - rbase, RST_CYC);
        check(frame_bad == fbase, "R2", "stop bits", frame_bad - fbase, 0);
        check(cap.size() - base == tot, effx ? "R5" : "R3", "frame count", cap.size() - base, tot);
        mism = -1;
        for (int i = 0; i < tot && base + i < cap.size(); i++)
            if (mism < 0 && cap[base + i] !== exp_byte(i, len, tot, s, e, alt)) mism = i;
        check(mism < 0, effx ? "R5" : "R4", "content first mismatch index", mism, -1);
        lo = 10*CPB + (effx ? 0 : GAP);
        hi = lo + CPB;
        check(d >= lo && d <= hi, "R7", "done delay after last start", d, lo);
        if (rx_inj)
            check(rx_cap.size() - rxbase == 1 && rx_cap[rx_cap.size()-1] == 8'hA5,
                  "R10", "echoed byte", rx_cap.size() - rxbase, 1);
        else
            check(rx_cap.size() == rxbase, "R10", "no spurious echo", rx_cap.size() - rxbase, 0);
    endtask

    task automatic run_bad(int len, bit fx, bit q, string req);
        int base, rbase;
        base = cap.size(); rbase = rst_seen;
        pulse_cmd(len, fx, q, 0, 16'h1234, 16'h5678);
        repeat (3 * CPB * 10) @(negedge clk);
        check(err === 1'b1 && done === 1'b0 && busy === 1'b0, req, "rejected status", err, 1);
        check(cap.size() == base && rst_seen == rbase && tx === 1'b1, req, "nothing sent",
              cap.size() - base, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 7);
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(tx === 1 && busy === 0 && done === 0 && err === 0 && tgt_reset === 0,
              "R9", "reset state", {tx, busy, done, err, tgt_reset}, 5'b10000);
        // R3 R4 R7 sweep of variable lengths, both memory maps
        for (int l = 1; l <= 12; l++)
            run(l, 0, 0, l[0], 16'(16'h0100 + l), 16'(16'hF000 - l), 0, 0);
        run(64, 0, 0, 0, 16'hB600, 16'hB7FF, 0, 0);
        // R5 fixed lengths incl. empty and largest
        run(0, 1, 0, 0, 16'h0000, 16'h00FF, 0, 0);
        run(5, 1, 0, 1, 16'h0040, 16'h013F, 0, 0);
        run(24, 1, 0, 0, 16'hABCD, 16'hEF01, 0, 0);
        // R6 query forces fixed
        run(5, 0, 1, 0, 16'h2222, 16'h3333, 0, 0);
        // R9 command during transfer ignored
        run(8, 0, 0, 0, 16'h4444, 16'h5555, 1, 0);
        // R10 echo while busy
        run(8, 0, 0, 1, 16'h6666, 16'h7777, 0, 1);
        begin
            int rb;
            rb = rx_cap.size();
            send_rx(8'h3C);
            repeat (20) @(negedge clk);
            check(rx_cap.size() == rb, "R10", "no echo while idle", rx_cap.size() - rb, 0);
        end
        // R8 rejections; R6 query with oversize length is rejected as fixed
        run_bad(0, 0, 0, "R8");
        run_bad(65, 0, 0, "R8");
        run_bad(25, 1, 0, "R8");
        run_bad(25, 0, 1, "R6");
        run(3, 0, 0, 0, 16'h0001, 16'h0002, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule